// File: doc/BRIEF.md
# Password and Authentication Access Gate

This block holds the security session state that decides which user zones of a protected memory may be read or written. It does no cryptography. Other logic verifies passwords, runs the authentication exchange and checks message authentication codes, and it reports each outcome here as a one-cycle strobe with a pass or fail flag. The gate remembers only the most recent accepted password and the most recent authentication. It tracks the session mode and counts consecutive failures for each password set and each key, locking an index after too many misses.

Each zone has its own configuration inputs. They say whether the zone needs a password and which set, whether it needs authentication and with which key, and whether it needs the encrypted mode. The per-zone read and write enables are decoded from the registered session state and these configuration inputs. A change to the state is therefore visible on the outputs in the cycle after the strobe that caused it.

Top module: `access_gate`

## Requirements
- R1: After power reset (`rst_n` low) the mode is standard (`mode_o` = 2'b00), no password or authentication is held, and all lock flags are 0. Only zones that need neither a password nor authentication nor encryption are readable and writable.
- R2: An accepted passing password verify makes that set the only active password, replacing any earlier one. A zone that needs a password is usable only when its configured set equals the active set.
- R3: A passing verify with `pw_write_i`=1 grants both read and write on matching zones. With `pw_write_i`=0 it grants read only. A zone is never writable without also being readable.
- R4: An accepted failing password verify removes the previously held password, even when it was for a different set.
- R5: An accepted passing authentication sets the mode to authenticated (2'b01) with that key. An accepted failing one drops the mode to standard (2'b00) and loses the earlier authentication.
- R6: Each password set and each key has its own consecutive-failure count. A pass clears it. On the fourth consecutive failure the index's lock flag rises, the flag stays high until power reset, and every later attempt on that index is ignored.
- R7: `enc_req_i` moves the mode from authenticated to encrypted (2'b10). In standard mode the request is ignored. Mode 2'b11 never occurs.
- R8: A MAC mismatch (`mac_valid_i`=1, `mac_ok_i`=0) while in authenticated or encrypted mode raises `mac_abort_o` in that cycle, and the mode returns to standard. In standard mode a mismatch has no effect.
- R9: `rst_pin_i` clears the held password and returns the mode to standard. Attempts in the same cycle are ignored. Failure counts and lock flags are kept.
- R10: A zone that needs authentication is usable only when the mode is not standard and its configured key equals the held key. A zone that needs encryption is usable only in encrypted mode.
- R11: A MAC mismatch and an accepted password verify in the same cycle both take effect: the mode drops and the new password becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power reset, clears everything |
| rst_pin_i | input | 1 | Reset-pin event, clears session but not failure counts |
| pw_valid_i | input | 1 | Password verify result strobe |
| pw_set_i | input | 3 | Password set index |
| pw_write_i | input | 1 | 1 = write password, 0 = read password |
| pw_pass_i | input | 1 | Verify outcome, 1 = pass |
| au_valid_i | input | 1 | Authentication result strobe |
| au_key_i | input | 2 | Key set index |
| au_pass_i | input | 1 | Authentication outcome, 1 = pass |
| enc_req_i | input | 1 | Encryption activation request |
| mac_valid_i | input | 1 | MAC check result strobe |
| mac_ok_i | input | 1 | 1 = MAC matched |
| cfg_pw_need_i | input | NZONE | Per zone: password required |
| cfg_pw_sel_i | input | NZONE*3 | Per zone: required password set, zone z at bits [3z+2:3z] |
| cfg_au_need_i | input | NZONE | Per zone: authentication required |
| cfg_key_sel_i | input | NZONE*2 | Per zone: required key, zone z at bits [2z+1:2z] |
| cfg_enc_need_i | input | NZONE | Per zone: encrypted mode required |
| zone_rd_o | output | NZONE | Per zone read enable |
| zone_wr_o | output | NZONE | Per zone write enable |
| mode_o | output | 2 | 00 standard, 01 authenticated, 10 encrypted |
| pw_lock_o | output | 8 | Per password set: attempts exhausted |
| au_lock_o | output | 4 | Per key: attempts exhausted |
| mac_abort_o | output | 1 | Current command aborted by MAC mismatch |

## Verification
A MAC mismatch and a password verify can land in the same cycle. One drops the session mode and the other changes the password register. The bench sets up an authenticated session with one password held, then asserts a mismatch strobe and a passing read-password strobe for another set together. After the edge it expects standard mode, the new set's zone readable but not writable, and the authenticated zone closed. The bench also drives the reset-pin event together with a passing verify to confirm that the reset pin wins.

// File: rtl/ag_pkg.sv
package ag_pkg;
    parameter int unsigned PW_SETS   = 8;
    parameter int unsigned KEY_SETS  = 4;
    parameter int unsigned PW_IDX_W  = $clog2(PW_SETS);
    parameter int unsigned KEY_IDX_W = $clog2(KEY_SETS);

    typedef enum logic [1:0] {
        MODE_STD  = 2'b00,
        MODE_AUTH = 2'b01,
        MODE_ENC  = 2'b10
    } mode_e;

    typedef struct packed {
        logic                 pw_act;
        logic                 pw_wr;
        logic [PW_IDX_W-1:0]  pw_idx;
        logic [KEY_IDX_W-1:0] key;
        mode_e                mode;
    } gate_state_t;
endpackage

// File: rtl/ag_strike_ctr.sv
module ag_strike_ctr #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic try_i,
    input  logic pass_i,
    output logic lock_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (try_i) begin
            if (pass_i) cnt_d = '0;
            else        cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign lock_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/ag_zone_decode.sv
module ag_zone_decode import ag_pkg::*; #(
    parameter int unsigned NZONE = 4
) (
    input  gate_state_t                st_i,
    input  logic [NZONE-1:0]           pw_need_i,
    input  logic [NZONE*PW_IDX_W-1:0]  pw_sel_i,
    input  logic [NZONE-1:0]           au_need_i,
    input  logic [NZONE*KEY_IDX_W-1:0] key_sel_i,
    input  logic [NZONE-1:0]           enc_need_i,
    output logic [NZONE-1:0]           rd_o,
    output logic [NZONE-1:0]           wr_o
);
    for (genvar z = 0; z < NZONE; z++) begin : g_zone
        logic pw_hit, pw_rd_ok, pw_wr_ok, au_ok, enc_ok;
        assign pw_hit   = st_i.pw_act && (st_i.pw_idx == pw_sel_i[z*PW_IDX_W +: PW_IDX_W]);
        assign pw_rd_ok = !pw_need_i[z] || pw_hit;
        assign pw_wr_ok = !pw_need_i[z] || (pw_hit && st_i.pw_wr);
        assign au_ok    = !au_need_i[z] ||
                          ((st_i.mode != MODE_STD) &&
                           (st_i.key == key_sel_i[z*KEY_IDX_W +: KEY_IDX_W]));
        assign enc_ok   = !enc_need_i[z] || (st_i.mode == MODE_ENC);
        assign rd_o[z]  = pw_rd_ok && au_ok && enc_ok;
        assign wr_o[z]  = pw_wr_ok && au_ok && enc_ok;
    end
endmodule

// File: rtl/access_gate.sv
module access_gate import ag_pkg::*; #(
    parameter int unsigned NZONE        = 4,
    parameter int unsigned STRIKE_LIMIT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rst_pin_i,
    input  logic                       pw_valid_i,
    input  logic [PW_IDX_W-1:0]        pw_set_i,
    input  logic                       pw_write_i,
    input  logic                       pw_pass_i,
    input  logic                       au_valid_i,
    input  logic [KEY_IDX_W-1:0]       au_key_i,
    input  logic                       au_pass_i,
    input  logic                       enc_req_i,
    input  logic                       mac_valid_i,
    input  logic                       mac_ok_i,
    input  logic [NZONE-1:0]           cfg_pw_need_i,
    input  logic [NZONE*PW_IDX_W-1:0]  cfg_pw_sel_i,
    input  logic [NZONE-1:0]           cfg_au_need_i,
    input  logic [NZONE*KEY_IDX_W-1:0] cfg_key_sel_i,
    input  logic [NZONE-1:0]           cfg_enc_need_i,
    output logic [NZONE-1:0]           zone_rd_o,
    output logic [NZONE-1:0]           zone_wr_o,
    output logic [1:0]                 mode_o,
    output logic [PW_SETS-1:0]         pw_lock_o,
    output logic [KEY_SETS-1:0]        au_lock_o,
    output logic                       mac_abort_o
);
    gate_state_t st_d, st_q;
    logic pw_try, au_try, mac_bad;

    assign pw_try  = pw_valid_i && !rst_pin_i && !pw_lock_o[pw_set_i];
    assign au_try  = au_valid_i && !rst_pin_i && !au_lock_o[au_key_i];
    assign mac_bad = mac_valid_i && !mac_ok_i && (st_q.mode != MODE_STD);

    for (genvar p = 0; p < PW_SETS; p++) begin : g_pw_ctr
        ag_strike_ctr #(.LIMIT(STRIKE_LIMIT)) i_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .try_i  (pw_try && (pw_set_i == PW_IDX_W'(p))),
            .pass_i (pw_pass_i),
            .lock_o (pw_lock_o[p])
        );
    end

    for (genvar k = 0; k < KEY_SETS; k++) begin : g_au_ctr
        ag_strike_ctr #(.LIMIT(STRIKE_LIMIT)) i_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .try_i  (au_try && (au_key_i == KEY_IDX_W'(k))),
            .pass_i (au_pass_i),
            .lock_o (au_lock_o[k])
        );
    end

    always_comb begin
        st_d = st_q;
        if (rst_pin_i) begin
            st_d.pw_act = 1'b0;
            st_d.pw_wr  = 1'b0;
            st_d.mode   = MODE_STD;
        end else begin
            if (pw_try) begin
                if (pw_pass_i) begin
                    st_d.pw_act = 1'b1;
                    st_d.pw_wr  = pw_write_i;
                    st_d.pw_idx = pw_set_i;
                end else begin
                    st_d.pw_act = 1'b0;
                    st_d.pw_wr  = 1'b0;
                end
            end
            if (au_try) begin
                if (au_pass_i) begin
                    st_d.mode = MODE_AUTH;
                    st_d.key  = au_key_i;
                end else begin
                    st_d.mode = MODE_STD;
                end
            end else if (mac_bad) begin
                st_d.mode = MODE_STD;
            end else if (enc_req_i && (st_q.mode == MODE_AUTH)) begin
                st_d.mode = MODE_ENC;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pw_act: 1'b0, pw_wr: 1'b0, pw_idx: '0, key: '0, mode: MODE_STD};
        else        st_q <= st_d;
    end

    ag_zone_decode #(.NZONE(NZONE)) i_decode (
        .st_i       (st_q),
        .pw_need_i  (cfg_pw_need_i),
        .pw_sel_i   (cfg_pw_sel_i),
        .au_need_i  (cfg_au_need_i),
        .key_sel_i  (cfg_key_sel_i),
        .enc_need_i (cfg_enc_need_i),
        .rd_o       (zone_rd_o),
        .wr_o       (zone_wr_o)
    );

    assign mode_o      = st_q.mode;
    assign mac_abort_o = mac_bad;
endmodule

// File: rtl/ag_checker.sv
module ag_checker import ag_pkg::*; #(
    parameter int unsigned NZONE = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rst_pin_i,
    input logic                au_valid_i,
    input logic [NZONE-1:0]    zone_rd_o,
    input logic [NZONE-1:0]    zone_wr_o,
    input logic [1:0]          mode_o,
    input logic [PW_SETS-1:0]  pw_lock_o,
    input logic [KEY_SETS-1:0] au_lock_o,
    input logic                mac_abort_o
);
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);                                                      // R7
    AST_ENC_FROM_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> ($past(mode_o) != 2'b00));                       // R7
    AST_WR_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_wr_o & ~zone_rd_o) == '0);                                       // R3
    AST_MAC_DROPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_abort_o && !au_valid_i) |=> (mode_o == 2'b00));                   // R8
    AST_MAC_ONLY_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        mac_abort_o |-> (mode_o != 2'b00));                                    // R8
    AST_RST_PIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin_i |=> (mode_o == 2'b00));                                      // R9
    AST_PW_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pw_lock_o) & ~pw_lock_o) == '0);                                // R6
    AST_AU_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(au_lock_o) & ~au_lock_o) == '0);                                // R6
endmodule

bind access_gate ag_checker #(.NZONE(NZONE)) i_ag_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_pin_i   (rst_pin_i),
    .au_valid_i  (au_valid_i),
    .zone_rd_o   (zone_rd_o),
    .zone_wr_o   (zone_wr_o),
    .mode_o      (mode_o),
    .pw_lock_o   (pw_lock_o),
    .au_lock_o   (au_lock_o),
    .mac_abort_o (mac_abort_o)
);

// File: tb/test_access_gate.sv
module test_access_gate;
    localparam int NZ = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin = 1'b0;
    logic pw_valid = 1'b0, pw_write = 1'b0, pw_pass = 1'b0;
    logic [2:0] pw_set = '0;
    logic au_valid = 1'b0, au_pass = 1'b0;
    logic [1:0] au_key = '0;
    logic enc_req = 1'b0, mac_valid = 1'b0, mac_ok = 1'b1;
    logic [NZ-1:0] pw_need, au_need, enc_need;
    logic [NZ*3-1:0] pw_sel;
    logic [NZ*2-1:0] key_sel;
    logic [NZ-1:0] zrd, zwr;
    logic [1:0] mode;
    logic [7:0] pw_lock;
    logic [3:0] au_lock;
    logic abort;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // zone0: password set 3; zone1: key 2; zone2: key 1 + encryption; zone3: open
    assign pw_need  = 4'b0001;
    assign pw_sel   = {3'd0, 3'd0, 3'd0, 3'd3};
    assign au_need  = 4'b0110;
    assign key_sel  = {2'd0, 2'd1, 2'd2, 2'd0};
    assign enc_need = 4'b0100;

    access_gate i_access_gate (
        .clk(clk), .rst_n(rst_n), .rst_pin_i(rst_pin),
        .pw_valid_i(pw_valid), .pw_set_i(pw_set), .pw_write_i(pw_write), .pw_pass_i(pw_pass),
        .au_valid_i(au_valid), .au_key_i(au_key), .au_pass_i(au_pass),
        .enc_req_i(enc_req), .mac_valid_i(mac_valid), .mac_ok_i(mac_ok),
        .cfg_pw_need_i(pw_need), .cfg_pw_sel_i(pw_sel), .cfg_au_need_i(au_need),
        .cfg_key_sel_i(key_sel), .cfg_enc_need_i(enc_need),
        .zone_rd_o(zrd), .zone_wr_o(zwr), .mode_o(mode),
        .pw_lock_o(pw_lock), .au_lock_o(au_lock), .mac_abort_o(abort)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        pw_valid = 0; au_valid = 0; enc_req = 0; mac_valid = 0; mac_ok = 1; rst_pin = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic pw_try(logic [2:0] s, logic w, logic p);
        @(negedge clk);
        pw_valid = 1; pw_set = s; pw_write = w; pw_pass = p;
        step();
    endtask

    task automatic au_try(logic [1:0] k, logic p);
        @(negedge clk);
        au_valid = 1; au_key = k; au_pass = p;
        step();
    endtask

    task automatic enc_try();
        @(negedge clk);
        enc_req = 1;
        step();
    endtask

    task automatic t_reset();
        check("R1 mode", mode, 2'b00);
        check("R1 rd", zrd, 4'b1000);
        check("R1 wr", zwr, 4'b1000);
        check("R1 pw_lock", pw_lock, 0);
        check("R1 au_lock", au_lock, 0);
    endtask

    task automatic t_password();
        pw_try(3, 0, 1);
        check("R3 read pw rd", zrd, 4'b1001);
        check("R3 read pw wr", zwr, 4'b1000);
        pw_try(3, 1, 1);
        check("R3 write pw rd", zrd, 4'b1001);
        check("R3 write pw wr", zwr, 4'b1001);
        pw_try(5, 1, 1);
        check("R2 replaced rd", zrd, 4'b1000);
        pw_try(3, 1, 1);
        check("R2 back rd", zrd, 4'b1001);
        pw_try(4, 1, 0);
        check("R4 fail erases rd", zrd, 4'b1000);
        check("R4 fail erases wr", zwr, 4'b1000);
    endtask

    task automatic t_strikes();
        for (int i = 0; i < 3; i++) pw_try(6, 0, 0);
        check("R6 three fails no lock", pw_lock[6], 0);
        pw_try(6, 0, 1);
        for (int i = 0; i < 3; i++) pw_try(6, 0, 0);
        check("R6 pass cleared count", pw_lock[6], 0);
        pw_try(6, 0, 0);
        check("R6 fourth fail locks", pw_lock, 8'h40);
        pw_try(3, 1, 1);
        check("R6 other set usable", zwr, 4'b1001);
        pw_try(6, 0, 0);
        check("R6 locked attempt ignored", zwr, 4'b1001);
        for (int i = 0; i < 4; i++) au_try(0, 0);
        check("R6 key lock", au_lock, 4'b0001);
        au_try(0, 1);
        check("R6 locked key ignored", mode, 2'b00);
    endtask

    task automatic t_auth_enc();
        enc_try();
        check("R7 enc in standard ignored", mode, 2'b00);
        au_try(2, 1);
        check("R5 auth mode", mode, 2'b01);
        check("R10 key 2 zone", zrd, 4'b1011);
        au_try(1, 1);
        check("R10 key 1 needs enc", zrd, 4'b1001);
        enc_try();
        check("R7 enc mode", mode, 2'b10);
        check("R10 enc zone open", zrd, 4'b1101);
        au_try(1, 0);
        check("R5 failed auth mode", mode, 2'b00);
        check("R5 failed auth rd", zrd, 4'b1001);
    endtask

    task automatic t_mac();
        au_try(2, 1);
        @(negedge clk);
        mac_valid = 1; mac_ok = 0;
        #1 check("R8 abort pulse", abort, 1);
        step();
        check("R8 mode dropped", mode, 2'b00);
        @(negedge clk);
        mac_valid = 1; mac_ok = 0;
        #1 check("R8 no abort in standard", abort, 0);
        step();
        check("R8 standard unchanged", mode, 2'b00);
    endtask

    task automatic t_collide();
        pw_try(5, 1, 1);
        au_try(2, 1);
        @(negedge clk);
        mac_valid = 1; mac_ok = 0;
        pw_valid = 1; pw_set = 3; pw_write = 0; pw_pass = 1;
        step();
        check("R11 mode dropped", mode, 2'b00);
        check("R11 new pw rd", zrd, 4'b1001);
        check("R11 new pw wr", zwr, 4'b1000);
    endtask

    task automatic t_rst_pin();
        pw_try(3, 1, 1);
        au_try(2, 1);
        @(negedge clk);
        rst_pin = 1;
        pw_valid = 1; pw_set = 3; pw_write = 1; pw_pass = 1;
        step();
        check("R9 mode", mode, 2'b00);
        check("R9 rd", zrd, 4'b1000);
        check("R9 locks kept", {pw_lock, au_lock}, {8'h40, 4'b0001});
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_password();
        t_strikes();
        t_auth_enc();
        t_mac();
        t_collide();
        t_rst_pin();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule